// File: doc/BRIEF.md
# Dual-Strobe Presettable BCD Decade Counter

This block holds one decimal digit (0 to 9) and moves it with two separate strobes: a rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one. There is no direction bit. Both strobes are plain level inputs that a system clock samples. An edge is seen when a strobe was low at one clock edge and is high at the next. A level-sensitive load copies a preset digit in, and a clear returns the digit to zero. Clear ranks above load.

Two active-low outputs flag the ends of the range. The carry output is low while the digit is 9 and the up strobe is low. The borrow output is low while the digit is 0 and the down strobe is low. Both are combinational, so each one rises at the same moment as the strobe that wraps the digit. That lets them feed the up and down strobes of the next decade directly, and a chain of copies forms a multi-digit counter.

Each clock edge the control decoder picks one of five named actions: HOLD, CLEAR, LOAD, INC and DEC. The priority is CLEAR, then LOAD, then a valid INC or DEC, then HOLD. The digit register moves only on CLEAR (to zero), LOAD (to the preset), INC (wrap 9 to 0) and DEC (wrap 0 to 9). HOLD keeps the current value.

Top module: `bcd_updn_decade`

## Requirements
- R1: While `load_n` is low and `clr` is low, every clock edge copies `preset` into `count`. Strobe edges seen in those cycles change nothing else.
- R2: An up edge counts up by one at the clock edge where it is seen. An up edge means `up_stb` was low at the previous clock edge and is high at this one. It counts only when `dn_stb` is high at both edges, `load_n` is high and `clr` is low. Counting up from 9 gives 0.
- R3: A down edge counts down by one in the same way. It counts only when `up_stb` is high at both edges, `load_n` is high and `clr` is low. Counting down from 0 gives 9.
- R4: While `clr` is high, every clock edge sets `count` to 0, whatever `load_n`, `preset` and the strobes are doing.
- R5: A strobe edge seen while the other strobe is low leaves `count` unchanged. Up and down edges seen at the same clock edge also leave `count` unchanged.
- R6: `carry_n` is low exactly while `count` is 9 and `up_stb` is low. `borrow_n` is low exactly while `count` is 0 and `dn_stb` is low. Both are combinational.
- R7: From a loaded value of 10 to 15, an up count gives 0 and a down count gives the value minus one.
- R8: When `carry_n` drives the next stage's `up_stb` and `borrow_n` drives its `dn_stb`, the next stage counts exactly once for each wrap of this stage, in the same clock edge as the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes and updates the digit |
| clr | input | 1 | Active-high clear. Has the highest priority |
| load_n | input | 1 | Active-low preset load |
| preset | input | 4 | Digit copied in by a load |
| up_stb | input | 1 | Count-up strobe. Acts on its rising edge |
| dn_stb | input | 1 | Count-down strobe. Acts on its rising edge |
| count | output | 4 | Current digit |
| carry_n | output | 1 | Active-low terminal-9 flag, gated by the low phase of the up strobe |
| borrow_n | output | 1 | Active-low terminal-0 flag, gated by the low phase of the down strobe |

## Verification
The checker checks the per-edge behaviour on every cycle. That covers the step taken for a valid up or down edge, load and clear, the hold when the strobes conflict, and the fact that a low carry or borrow always means the digit is at the matching end. The scenarios in the bench are needed for the rest. They cover the carry and borrow going high again exactly as the wrapping strobe rises, the recovery path from the invalid codes 10 to 15, and a two-decade chain that must advance its upper digit exactly once per wrap in both directions.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    // Action chosen for the digit register at each clock edge
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_INC   = 3'd3,
        ACT_DEC   = 3'd4
    } act_e;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise
);

    // One sampling flop per strobe lane; a rise is low-then-high across edges
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic prev_q;

        always_ff @(posedge clk) begin
            prev_q <= lvl[g];
        end

        assign rise[g] = lvl[g] & ~prev_q;
    end

endmodule

// File: rtl/bcd_act_dec.sv
module bcd_act_dec
    import bcd_cnt_pkg::*;
(
    input  logic clr,
    input  logic load_n,
    input  logic up_lvl,
    input  logic dn_lvl,
    input  logic up_rise,
    input  logic dn_rise,
    output act_e act
);

    logic inc_ok;
    logic dec_ok;

    // A count needs the opposite strobe to have been high at both edges
    assign inc_ok = up_rise & dn_lvl & ~dn_rise;
    assign dec_ok = dn_rise & up_lvl & ~up_rise;

    always_comb begin
        if (clr)
            act = ACT_CLEAR;
        else if (!load_n)
            act = ACT_LOAD;
        else if (inc_ok)
            act = ACT_INC;
        else if (dec_ok)
            act = ACT_DEC;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/bcd_next.sv
module bcd_next
    import bcd_cnt_pkg::*;
#(
    parameter int DIG_W = 4,
    parameter int TOP_V = 9
) (
    input  act_e             act,
    input  logic [DIG_W-1:0] cur,
    input  logic [DIG_W-1:0] preset,
    output logic [DIG_W-1:0] nxt
);

    localparam logic [DIG_W-1:0] TOP_C  = DIG_W'(TOP_V);
    localparam logic [DIG_W-1:0] ZERO_C = '0;
    localparam logic [DIG_W-1:0] ONE_C  = DIG_W'(1);

    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = ZERO_C;
            ACT_LOAD:  nxt = preset;
            ACT_INC:   nxt = (cur >= TOP_C) ? ZERO_C : cur + ONE_C;
            ACT_DEC:   nxt = (cur == ZERO_C) ? TOP_C : cur - ONE_C;
            ACT_HOLD:  nxt = cur;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcd_updn_decade.sv
module bcd_updn_decade
    import bcd_cnt_pkg::*;
#(
    parameter int DIG_W = 4,
    parameter int TOP_V = 9
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_n,
    input  logic [DIG_W-1:0] preset,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [DIG_W-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam int           LANES  = 2;
    localparam int           L_UP   = 0;
    localparam int           L_DN   = 1;
    localparam logic [DIG_W-1:0] TOP_C = DIG_W'(TOP_V);

    logic [LANES-1:0] stb_lvl;
    logic [LANES-1:0] stb_rise;
    act_e             act;
    logic [DIG_W-1:0] cnt_q;
    logic [DIG_W-1:0] cnt_d;

    assign stb_lvl[L_UP] = up_stb;
    assign stb_lvl[L_DN] = dn_stb;

    strobe_edge #(.LANES(LANES)) u_edge (
        .clk  (clk),
        .lvl  (stb_lvl),
        .rise (stb_rise)
    );

    bcd_act_dec u_dec (
        .clr     (clr),
        .load_n  (load_n),
        .up_lvl  (up_stb),
        .dn_lvl  (dn_stb),
        .up_rise (stb_rise[L_UP]),
        .dn_rise (stb_rise[L_DN]),
        .act     (act)
    );

    bcd_next #(.DIG_W(DIG_W), .TOP_V(TOP_V)) u_next (
        .act    (act),
        .cur    (cnt_q),
        .preset (preset),
        .nxt    (cnt_d)
    );

    // Digit register
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // Outputs: terminal flags gated by the low phase of their strobe
    always_comb begin
        count    = cnt_q;
        carry_n  = ~((cnt_q == TOP_C) & ~up_stb);
        borrow_n = ~((cnt_q == '0) & ~dn_stb);
    end

endmodule

// File: rtl/bcd_updn_decade_chk.sv
module bcd_updn_decade_chk #(
    parameter int DIG_W = 4,
    parameter int TOP_V = 9
) (
    input logic             clk,
    input logic             clr,
    input logic             load_n,
    input logic [DIG_W-1:0] preset,
    input logic             up_stb,
    input logic             dn_stb,
    input logic [DIG_W-1:0] count,
    input logic             carry_n,
    input logic             borrow_n
);

    localparam logic [DIG_W-1:0] TOP_C = DIG_W'(TOP_V);
    localparam logic [DIG_W-1:0] ONE_C = DIG_W'(1);

    a_r1_load_copies: assert property (@(posedge clk) disable iff (clr)
        !load_n |=> count == $past(preset));

    a_r2_up_step: assert property (@(posedge clk) disable iff (clr)
        (load_n && up_stb && !$past(up_stb) && dn_stb && $past(dn_stb))
        |=> count == (($past(count) >= TOP_C) ? '0 : $past(count) + ONE_C));

    a_r3_down_step: assert property (@(posedge clk) disable iff (clr)
        (load_n && dn_stb && !$past(dn_stb) && up_stb && $past(up_stb))
        |=> count == (($past(count) == '0) ? TOP_C : $past(count) - ONE_C));

    a_r4_clear_zero: assert property (@(posedge clk)
        clr |=> count == '0);

    a_r5_conflict_hold: assert property (@(posedge clk) disable iff (clr)
        (load_n && ((up_stb && !$past(up_stb) && !(dn_stb && $past(dn_stb))) ||
                    (dn_stb && !$past(dn_stb) && !(up_stb && $past(up_stb)))))
        |=> $stable(count));

    a_r6_carry_at_top: assert property (@(posedge clk) disable iff (clr)
        !carry_n |-> count == TOP_C);

    a_r6_borrow_at_zero: assert property (@(posedge clk) disable iff (clr)
        !borrow_n |-> count == '0);

endmodule

bind bcd_updn_decade bcd_updn_decade_chk #(.DIG_W(DIG_W), .TOP_V(TOP_V)) u_chk (
    .clk      (clk),
    .clr      (clr),
    .load_n   (load_n),
    .preset   (preset),
    .up_stb   (up_stb),
    .dn_stb   (dn_stb),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/bcd_updn_decade_tb_top.sv
`timescale 1ns/1ps
module bcd_updn_decade_tb_top;

    typedef struct {
        logic [3:0] lo;
        logic       cy;
        logic       bo;
        logic [3:0] hi;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       up_stb = 1'b1;
    logic       dn_stb = 1'b1;
    logic [3:0] lo_count;
    logic       lo_cy_n;
    logic       lo_bo_n;
    logic [3:0] hi_count;
    logic       hi_cy_n;
    logic       hi_bo_n;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    // bench model state
    logic [3:0] m_lo = 4'd0, m_hi = 4'd0;
    logic       p_up = 1'b1, p_dn = 1'b1, p_cy = 1'b1, p_bo = 1'b1;

    always #2.5 clk = ~clk;

    bcd_updn_decade dut_i (
        .clk(clk), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up_stb), .dn_stb(dn_stb),
        .count(lo_count), .carry_n(lo_cy_n), .borrow_n(lo_bo_n)
    );

    // upper decade fed from the lower decade's terminal flags (R8)
    bcd_updn_decade stage_hi (
        .clk(clk), .clr(clr), .load_n(1'b1), .preset(4'd0),
        .up_stb(lo_cy_n), .dn_stb(lo_bo_n),
        .count(hi_count), .carry_n(hi_cy_n), .borrow_n(hi_bo_n)
    );

    function automatic logic [3:0] step(input logic [3:0] c, input logic u, input logic d,
                                        input logic pu, input logic pd, input logic ld_n,
                                        input logic [3:0] p, input logic cl);
        logic ru, rd;
        ru = u & ~pu;
        rd = d & ~pd;
        if (cl) return 4'd0;
        if (!ld_n) return p;
        if (ru && d && !rd) return (c >= 4'd9) ? 4'd0 : c + 4'd1;
        if (rd && u && !ru) return (c == 4'd0) ? 4'd9 : c - 4'd1;
        return c;
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic cyc(input logic u, input logic d, input logic ld_n,
                       input logic [3:0] p, input logic cl, input string tag);
        logic cy_now, bo_now;
        logic [3:0] lo_n, hi_n;
        exp_t e;
        @(negedge clk);
        up_stb = u; dn_stb = d; load_n = ld_n; preset = p; clr = cl;
        cy_now = ~((m_lo == 4'd9) & ~u);
        bo_now = ~((m_lo == 4'd0) & ~d);
        lo_n = step(m_lo, u, d, p_up, p_dn, ld_n, p, cl);
        hi_n = step(m_hi, cy_now, bo_now, p_cy, p_bo, 1'b1, 4'd0, cl);
        p_up = u; p_dn = d; p_cy = cy_now; p_bo = bo_now;
        m_lo = lo_n; m_hi = hi_n;
        e.lo = m_lo;
        e.cy = ~((m_lo == 4'd9) & ~u);
        e.bo = ~((m_lo == 4'd0) & ~d);
        e.hi = m_hi;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic up_pulses(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, 1'b1, 4'd0, 1'b0, tag);
            cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, tag);
        end
    endtask

    task automatic dn_pulses(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, tag);
            cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, tag);
        end
    endtask

    // monitor: compares one settled time unit after each active edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_checks++;
                if (lo_count !== e.lo || lo_cy_n !== e.cy || lo_bo_n !== e.bo || hi_count !== e.hi) begin
                    n_fail++;
                    $display("FAIL %s: got lo=%0d cy_n=%b bo_n=%b hi=%0d, expected lo=%0d cy_n=%b bo_n=%b hi=%0d",
                             e.tag, lo_count, lo_cy_n, lo_bo_n, hi_count, e.lo, e.cy, e.bo, e.hi);
                end
            end
        end
    end

    initial begin
        #200us;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R4: clear from power-up
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b1, "R4 reset clear");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b1, "R4 reset clear");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R4 idle after clear");
        // R2: count up through 9 with carry low in the low phase, wrap to 0
        up_pulses(9, "R2 up count");
        cyc(1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R6 carry low at 9");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R2 wrap 9 to 0");
        // R3: count down with borrow, wrap 0 to 9
        cyc(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, "R6 borrow low at 0");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R3 wrap 0 to 9");
        dn_pulses(3, "R3 down count");
        // R5: up edge while down strobe low, then simultaneous edges
        cyc(1'b0, 1'b0, 1'b1, 4'd0, 1'b0, "R5 both low");
        cyc(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, "R5 up edge with down low");
        cyc(1'b0, 1'b0, 1'b1, 4'd0, 1'b0, "R5 both low");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R5 simultaneous edges");
        cyc(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, "R5 down low");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R5 down edge allowed");
        // R1: load with strobe activity ignored
        cyc(1'b0, 1'b1, 1'b0, 4'd7, 1'b0, "R1 load 7");
        cyc(1'b1, 1'b1, 1'b0, 4'd7, 1'b0, "R1 up edge during load");
        cyc(1'b1, 1'b1, 1'b1, 4'd3, 1'b0, "R1 load released");
        // R7: recovery from invalid codes
        cyc(1'b1, 1'b1, 1'b0, 4'd12, 1'b0, "R7 load 12");
        up_pulses(1, "R7 up from 12");
        cyc(1'b1, 1'b1, 1'b0, 4'd15, 1'b0, "R7 load 15");
        dn_pulses(1, "R7 down from 15");
        cyc(1'b1, 1'b1, 1'b0, 4'd10, 1'b0, "R7 load 10");
        dn_pulses(1, "R7 down from 10");
        // R4: clear beats load
        cyc(1'b1, 1'b1, 1'b0, 4'd6, 1'b1, "R4 clear over load");
        cyc(1'b0, 1'b1, 1'b1, 4'd6, 1'b1, "R4 clear ignores strobe");
        cyc(1'b1, 1'b1, 1'b1, 4'd6, 1'b1, "R4 clear ignores strobe");
        cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R4 idle");
        // R8: two-decade chain up and down across several wraps
        up_pulses(25, "R8 cascade up");
        dn_pulses(30, "R8 cascade down");
        up_pulses(7, "R8 cascade up again");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule